// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is the host side of a three-wire serial EEPROM link: a select line, a shift clock and one data line in each direction. It reads one 16-bit word per access. It first finds out how many address bits the attached device takes. It does this by reading word 0 with eight address bits and comparing the result with a fixed signature. It then fetches a 48-bit station address from three fixed word locations and holds it on an output.

Once that start-up sequence is over, a requester presents a word address with a one-cycle start pulse. The result comes back on `rdData` together with a one-cycle `done` pulse. The shift clock runs at the system clock divided by twice the `CLK_DIV` parameter. Each half-period of the shift clock lasts `CLK_DIV` system cycles, and `CLK_DIV` is at least 1. Write and erase opcodes are defined as constants for future use, but the block never issues them.

Top module: `eeprom_reader`

## Requirements
- R1: After reset, the block reads word 0 with an 8-bit address. `wideAddr` goes to 1 if that word equals 16'h8129 and to 0 otherwise. `wideAddr` then holds its value until the next reset.
- R2: After the width probe, the block reads words 7, 8 and 9 and then raises `stationValid`, which stays high until reset. Station byte k sits at `stationAddr[8k+7:8k]`. Byte 2j is the low byte of word 7+j and byte 2j+1 is its high byte, so `stationAddr` = {word9, word8, word7}.
- R3: Every access sends the read opcode 3'b110 (start bit first) followed by the address, most significant bit first. That is 3+W bits, one per rising edge of `eeSk`.
- R4: Before an access, `eeCs` stays low for at least one half-period and then rises while `eeSk` is low. `eeSk` is high only while `eeCs` is high. At the end, `eeCs` falls while `eeSk` is low.
- R5: `eeDi` changes only while `eeSk` is low, so it is stable through every high phase of `eeSk`.
- R6: After the command and one low half-period, the block applies 16 clock pulses. It samples `eeDo` at the end of each high phase, most significant bit first, and the resulting word appears on `rdData` in the cycle `done` is high.
- R7: Every high phase of `eeSk`, and every low phase between two high phases within one access, lasts exactly `CLK_DIV` system clocks.
- R8: `busy` is high from reset through the whole start-up sequence, and from the cycle after an accepted `start` until the cycle `done` is high, in which `busy` is already low. `done` is a single-cycle pulse and never fires for the start-up reads.
- R9: A `start` while `busy` is high is ignored. No extra access is made, no extra `done` is produced, and the address of the access already under way is unchanged.
- R10: With `wideAddr` = 1, a requester read sends `wordAddr[7:0]`. With `wideAddr` = 0, it sends `wordAddr[5:0]` and ignores the upper two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request for a word read |
| wordAddr | input | 8 | Word address of the request |
| busy | output | 1 | Start-up sequence or an access is in progress |
| done | output | 1 | One-cycle pulse: `rdData` holds the requested word |
| rdData | output | 16 | Last word returned to the requester |
| wideAddr | output | 1 | 1: device takes 8 address bits, 0: 6 bits |
| stationAddr | output | 48 | Station address assembled from words 7 to 9 |
| stationValid | output | 1 | Station address has been loaded |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM shift clock |
| eeDi | output | 1 | Serial data to the EEPROM |
| eeDo | input | 1 | Serial data from the EEPROM |

## Verification
The assertions check the pin-level rules on every cycle. These are the shift clock only toggling under chip select, select falling only with the clock low, and data held steady across each clock-high phase. They also check that `done` is a lone pulse with `busy` already low, that the address of a running request never changes, and that the detected width and the station-valid flag stay fixed once the station address is loaded. Only the bench's scenarios can show the content behind those rules. Its EEPROM model decodes the opcode and address bits, so the scenarios confirm the width decision against a device of each size and the byte order of the station address. They also check that a narrow device sees only six address bits, the exact half-period length in system clocks, and that a start issued mid-access leaves no trace on the wires.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
  localparam int WORD_BITS     = 16;
  localparam int OPC_BITS      = 3;
  localparam int WIDE_BITS     = 8;
  localparam int NARROW_BITS   = 6;
  localparam int CMD_W         = OPC_BITS + WIDE_BITS;
  localparam int STATION_WORDS = 3;
  localparam int IDX_W         = 2;

  localparam logic [OPC_BITS-1:0]  OP_READ  = 3'b110;
  localparam logic [OPC_BITS-1:0]  OP_WRITE = 3'b101;
  localparam logic [OPC_BITS-1:0]  OP_ERASE = 3'b111;
  localparam logic [WORD_BITS-1:0] WIDE_SIGNATURE = 16'h8129;
  localparam logic [WIDE_BITS-1:0] STATION_BASE   = 8'd7;

  typedef enum logic [3:0] {
    PH_IDLE, PH_PRE, PH_CSUP, PH_CMDLO, PH_CMDHI,
    PH_GAP, PH_DATHI, PH_DATLO, PH_FIN
  } phase_e;

  typedef enum logic [1:0] {JOB_PROBE, JOB_STATION, JOB_REQ} job_e;

  typedef struct packed {
    logic                 loadCmd;
    logic                 forceWide;
    logic [WIDE_BITS-1:0] cmdAddr;
    logic                 shiftCmd;
    logic                 sampleBit;
    logic                 storeWidth;
    logic                 storeStation;
    logic [IDX_W-1:0]     stationIdx;
    logic                 storeReq;
  } strobe_t;
endpackage

// File: rtl/eerd_tick.sv
module eerd_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV + 1) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  initial begin
    if (DIV < 1) $error("DIV must be at least 1");
  end
endmodule

// File: rtl/eerd_ctrl.sv
module eerd_ctrl
  import eerd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WIDE_BITS-1:0] wordAddr,
  input  logic                 wideAddr,
  input  logic                 tick,
  output strobe_t              strb,
  output logic                 run,
  output logic                 eeCs,
  output logic                 eeSk,
  output logic                 diEn,
  output logic                 busy,
  output logic                 done
);
  localparam logic [3:0] LAST_WIDE   = 4'(CMD_W - 1);
  localparam logic [3:0] LAST_NARROW = 4'(OPC_BITS + NARROW_BITS - 1);
  localparam logic [3:0] LAST_DATA   = 4'(WORD_BITS - 1);

  phase_e state, stateNxt;
  job_e   job, jobNxt;
  logic [IDX_W-1:0]     stnIdx, stnIdxNxt;
  logic [WIDE_BITS-1:0] curAddr, curAddrNxt;
  logic [3:0]           bitCnt, bitCntNxt;
  logic                 initDone, initDoneNxt, doneNxt;
  logic [3:0]           lastCmdBit;

  assign lastCmdBit = (job == JOB_PROBE || wideAddr) ? LAST_WIDE : LAST_NARROW;
  assign run  = (state != PH_IDLE);
  assign busy = run || !initDone;
  assign diEn = (state == PH_CMDLO) || (state == PH_CMDHI);

  always_comb begin
    stateNxt    = state;
    jobNxt      = job;
    stnIdxNxt   = stnIdx;
    curAddrNxt  = curAddr;
    bitCntNxt   = bitCnt;
    initDoneNxt = initDone;
    doneNxt     = 1'b0;
    strb        = '0;
    strb.cmdAddr    = curAddr;
    strb.forceWide  = (job == JOB_PROBE);
    strb.stationIdx = stnIdx;
    unique case (state)
      PH_IDLE: begin
        if (!initDone) begin
          jobNxt = JOB_PROBE; curAddrNxt = '0; stateNxt = PH_PRE;
        end else if (start) begin
          jobNxt = JOB_REQ; curAddrNxt = wordAddr; stateNxt = PH_PRE;
        end
      end
      PH_PRE: if (tick) begin
        strb.loadCmd = 1'b1; bitCntNxt = '0; stateNxt = PH_CSUP;
      end
      PH_CSUP:  if (tick) stateNxt = PH_CMDLO;
      PH_CMDLO: if (tick) stateNxt = PH_CMDHI;
      PH_CMDHI: if (tick) begin
        strb.shiftCmd = 1'b1;
        if (bitCnt == lastCmdBit) begin bitCntNxt = '0; stateNxt = PH_GAP; end
        else begin bitCntNxt = bitCnt + 1'b1; stateNxt = PH_CMDLO; end
      end
      PH_GAP:   if (tick) stateNxt = PH_DATHI;
      PH_DATHI: if (tick) begin strb.sampleBit = 1'b1; stateNxt = PH_DATLO; end
      PH_DATLO: if (tick) begin
        if (bitCnt == LAST_DATA) stateNxt = PH_FIN;
        else begin bitCntNxt = bitCnt + 1'b1; stateNxt = PH_DATHI; end
      end
      PH_FIN: if (tick) begin
        unique case (job)
          JOB_PROBE: begin
            strb.storeWidth = 1'b1;
            jobNxt = JOB_STATION; stnIdxNxt = '0;
            curAddrNxt = STATION_BASE; stateNxt = PH_PRE;
          end
          JOB_STATION: begin
            strb.storeStation = 1'b1;
            if (stnIdx == IDX_W'(STATION_WORDS - 1)) begin
              initDoneNxt = 1'b1; stateNxt = PH_IDLE;
            end else begin
              stnIdxNxt  = stnIdx + 1'b1;
              curAddrNxt = STATION_BASE + WIDE_BITS'(stnIdx + 1'b1);
              stateNxt   = PH_PRE;
            end
          end
          default: begin
            strb.storeReq = 1'b1; doneNxt = 1'b1; stateNxt = PH_IDLE;
          end
        endcase
      end
      default: stateNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE; job <= JOB_PROBE; stnIdx <= '0; curAddr <= '0;
      bitCnt <= '0; initDone <= 1'b0; done <= 1'b0; eeCs <= 1'b0; eeSk <= 1'b0;
    end else begin
      state    <= stateNxt;
      job      <= jobNxt;
      stnIdx   <= stnIdxNxt;
      curAddr  <= curAddrNxt;
      bitCnt   <= bitCntNxt;
      initDone <= initDoneNxt;
      done     <= doneNxt;
      eeSk     <= (stateNxt == PH_CMDHI) || (stateNxt == PH_DATHI);
      eeCs     <= (stateNxt inside {PH_CSUP, PH_CMDLO, PH_CMDHI, PH_GAP, PH_DATHI, PH_DATLO});
    end
  end

  // R4
  sk_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) eeSk |-> eeCs);
  // R4
  cs_drop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eeCs) |-> (!eeSk && !$past(eeSk)));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R9
  req_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (job == JOB_REQ && state != PH_IDLE) |=> $stable(curAddr));
endmodule

// File: rtl/eerd_datapath.sv
module eerd_datapath
  import eerd_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  strobe_t                             strb,
  input  logic                                eeDo,
  output logic                                cmdBit,
  output logic                                wideAddr,
  output logic [WORD_BITS-1:0]                rdData,
  output logic [STATION_WORDS*WORD_BITS-1:0]  stationAddr,
  output logic                                stationValid
);
  logic [CMD_W-1:0]     cmdReg;
  logic [WORD_BITS-1:0] shiftData;

  assign cmdBit = cmdReg[CMD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg <= '0; shiftData <= '0; wideAddr <= 1'b0; rdData <= '0; stationValid <= 1'b0;
    end else begin
      if (strb.loadCmd) begin
        if (strb.forceWide || wideAddr) cmdReg <= {OP_READ, strb.cmdAddr};
        else cmdReg <= {OP_READ, strb.cmdAddr[NARROW_BITS-1:0], {(WIDE_BITS-NARROW_BITS){1'b0}}};
      end else if (strb.shiftCmd) begin
        cmdReg <= {cmdReg[CMD_W-2:0], 1'b0};
      end
      if (strb.sampleBit) shiftData <= {shiftData[WORD_BITS-2:0], eeDo};
      if (strb.storeWidth) wideAddr <= (shiftData == WIDE_SIGNATURE);
      if (strb.storeReq) rdData <= shiftData;
      if (strb.storeStation && strb.stationIdx == IDX_W'(STATION_WORDS - 1)) stationValid <= 1'b1;
    end
  end

  for (genvar g = 0; g < STATION_WORDS; g++) begin : g_stn
    logic [WORD_BITS-1:0] word;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word <= '0;
      else if (strb.storeStation && strb.stationIdx == IDX_W'(g)) word <= shiftData;
    end
    assign stationAddr[g*WORD_BITS +: WORD_BITS] = word;
  end

  // R2
  station_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stationValid |=> stationValid);
  // R1
  width_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stationValid |=> $stable(wideAddr));
endmodule

// File: rtl/eeprom_reader.sv
module eeprom_reader
  import eerd_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  wordAddr,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        wideAddr,
  output logic [47:0] stationAddr,
  output logic        stationValid,
  output logic        eeCs,
  output logic        eeSk,
  output logic        eeDi,
  input  logic        eeDo
);
  strobe_t strb;
  logic    run, tick, diEn, cmdBit;

  eerd_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  eerd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wordAddr(wordAddr),
    .wideAddr(wideAddr), .tick(tick), .strb(strb), .run(run),
    .eeCs(eeCs), .eeSk(eeSk), .diEn(diEn), .busy(busy), .done(done)
  );

  eerd_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .eeDo(eeDo), .cmdBit(cmdBit),
    .wideAddr(wideAddr), .rdData(rdData), .stationAddr(stationAddr),
    .stationValid(stationValid)
  );

  assign eeDi = diEn & cmdBit;

  // R5
  di_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eeSk && $past(eeSk)) |-> $stable(eeDi));
  // R4
  di_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !eeCs |-> !eeDi);
endmodule

// File: tb/sim_eeprom_reader.sv
module sim_eeprom_reader;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, eeDo = 1'b0;
  logic [7:0] wordAddr = '0;
  logic busy, done, wideAddr, stationValid, eeCs, eeSk, eeDi;
  logic [15:0] rdData;
  logic [47:0] stationAddr;

  eeprom_reader #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wordAddr(wordAddr), .busy(busy),
    .done(done), .rdData(rdData), .wideAddr(wideAddr), .stationAddr(stationAddr),
    .stationValid(stationValid), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // EEPROM model
  int modelW = 8;
  logic [15:0] mem [0:255];
  int mBits = 0, outIdx = 0, cmdCount = 0;
  logic [10:0] shiftIn = '0;
  logic [15:0] outWord = '0;
  logic [2:0] opSeen [0:15];
  logic [7:0] addrSeen [0:15];

  always @(negedge eeCs) begin mBits = 0; eeDo = 1'b0; end

  always @(posedge eeSk) begin
    if (eeCs) begin
      if (mBits < 3 + modelW) begin
        shiftIn = {shiftIn[9:0], eeDi};
        mBits++;
        if (mBits == 3 + modelW) begin
          opSeen[cmdCount % 16]   = 3'(shiftIn >> modelW);
          addrSeen[cmdCount % 16] = 8'(shiftIn & ((11'd1 << modelW) - 11'd1));
          outWord = mem[8'(shiftIn & ((11'd1 << modelW) - 11'd1))];
          cmdCount++;
          outIdx = 0;
        end
      end else begin
        eeDo = (outIdx < 16) ? outWord[15 - outIdx] : 1'b0;
        outIdx++;
      end
    end
  end

  // pin monitors: framing (R4), data stability (R5), phase length (R7)
  int framingErr = 0, diErr = 0, timeErr = 0, doneCount = 0;
  int hiRun = 0, loRun = 0, csLowRun = 0;
  bit seenHi = 1'b0;
  logic prevSk = 1'b0, prevDi = 1'b0;

  always @(posedge eeCs) if (eeSk || csLowRun < DIV) framingErr++;
  always @(negedge eeCs) if (eeSk) framingErr++;

  always @(negedge clk) if (rst_n) begin
    if (done) doneCount++;
    if (eeSk && !eeCs) framingErr++;
    if (eeSk) begin
      hiRun++;
      if (prevSk && eeDi !== prevDi) diErr++;
      if (loRun != 0) begin
        if (seenHi && loRun != DIV) timeErr++;
        loRun = 0;
      end
      seenHi = 1'b1;
    end else begin
      if (hiRun != 0 && hiRun != DIV) timeErr++;
      hiRun = 0;
      if (eeCs) loRun++;
    end
    if (!eeCs) begin loRun = 0; seenHi = 1'b0; csLowRun++; end
    else csLowRun = 0;
    prevSk = eeSk; prevDi = eeDi;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitFor(input int which, input int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((which == 0 && stationValid) || (which == 1 && done)) begin ok = 1'b1; break; end
    end
  endtask

  task automatic tReset();
    chk("R4 cs low in reset", 64'(eeCs), 64'd0);
    chk("R4 sk low in reset", 64'(eeSk), 64'd0);
    chk("R8 done low in reset", 64'(done), 64'd0);
    chk("R8 busy high before start-up", 64'(busy), 64'd1);
    chk("R2 station not valid in reset", 64'(stationValid), 64'd0);
  endtask

  task automatic tInit(input logic expWide, input logic [47:0] expStation);
    bit ok;
    int base = cmdCount;
    rst_n = 1'b1;
    waitFor(0, 4000, ok);
    chk("R2 station valid reached", 64'(ok), 64'd1);
    chk("R1 width decision", 64'(wideAddr), 64'(expWide));
    chk("R2 station address byte order", 64'(stationAddr), 64'(expStation));
    chk("R8 busy low after start-up", 64'(busy), 64'd0);
    chk("R8 no done during start-up", 64'(doneCount), 64'd0);
    chk("R3 start-up access count", 64'(cmdCount - base), 64'd4);
    chk("R1 probe address 0", 64'(addrSeen[base % 16]), 64'd0);
    for (int k = 0; k < 3; k++)
      chk("R2 station word address", 64'(addrSeen[(base + 1 + k) % 16]), 64'(7 + k));
    for (int k = 0; k < 4; k++)
      chk("R3 read opcode 110", 64'(opSeen[(base + k) % 16]), 64'b110);
    repeat (20) @(negedge clk);
    chk("R2 station valid stays high", 64'(stationValid), 64'd1);
  endtask

  task automatic tRead(input logic [7:0] a, input logic [7:0] seenA);
    bit ok;
    int base = cmdCount, d0 = doneCount;
    @(negedge clk); start = 1'b1; wordAddr = a;
    @(negedge clk); start = 1'b0;
    chk("R8 busy after start", 64'(busy), 64'd1);
    waitFor(1, 2000, ok);
    chk("R8 done seen", 64'(ok), 64'd1);
    chk("R8 busy low with done", 64'(busy), 64'd0);
    chk("R6 word returned", 64'(rdData), 64'(mem[seenA]));
    chk("R10 address bits sent", 64'(addrSeen[base % 16]), 64'(seenA));
    chk("R3 request opcode", 64'(opSeen[base % 16]), 64'b110);
    @(negedge clk);
    chk("R8 single done pulse", 64'(doneCount - d0), 64'd1);
  endtask

  task automatic tIgnore();
    bit ok;
    int base = cmdCount, d0 = doneCount;
    @(negedge clk); start = 1'b1; wordAddr = 8'h33;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; wordAddr = 8'h44;
    @(negedge clk); start = 1'b0;
    waitFor(1, 2000, ok);
    chk("R9 first request completes", 64'(ok), 64'd1);
    chk("R9 address not replaced", 64'(rdData), 64'(mem[8'h33]));
    repeat (400) @(negedge clk);
    chk("R9 no second access", 64'(cmdCount - base), 64'd1);
    chk("R9 no second done", 64'(doneCount - d0), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0111) ^ 16'h5A00;
    mem[0] = 16'h8129;
    mem[7] = 16'h2211; mem[8] = 16'h4433; mem[9] = 16'h6655;
    repeat (5) @(negedge clk);
    tReset();
    tInit(1'b1, 48'h6655_4433_2211);
    tRead(8'hA5, 8'hA5);
    tRead(8'h00, 8'h00);
    tIgnore();
    // narrow device: probe returns a shifted word, so the width is 6
    @(negedge clk); rst_n = 1'b0; modelW = 6;
    mem[7] = 16'hBBAA; mem[8] = 16'hDDCC; mem[9] = 16'hFFEE;
    doneCount = 0;
    repeat (5) @(negedge clk);
    tInit(1'b0, 48'hFFEE_DDCC_BBAA);
    tRead(8'hC5, 8'h05);
    tRead(8'h3F, 8'h3F);
    chk("R4 select and clock framing", 64'(framingErr), 64'd0);
    chk("R5 data stable in clock high", 64'(diErr), 64'd0);
    chk("R7 half-period length", 64'(timeErr), 64'd0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule